// File: doc/BRIEF.md
# Packet Transmit Framer

The framer turns payload bytes into a complete serial frame for a radio modulator. The host writes payload bytes into a small transmit FIFO, sets the frame options and pulses a start request. The framer then sends a run of identical preamble bytes and a start pattern of one or more bytes. Next come an optional node-address byte and an optional length byte, then the payload taken from the FIFO, then an optional 16-bit CRC. One line chip is presented per bit-rate strobe. The next chip appears in the cycle after each strobe.

Two line codings can be switched on for everything that follows the start pattern. The first is a whitening scrambler that keeps the stream DC-balanced. The second is a Manchester coder that spends two chips on each bit. They may be used together; in that case scrambling comes first. The preamble and the start pattern always go out uncoded.

The host sees a busy flag while a frame is on the line and a one-cycle done pulse at its end. An underrun flag is raised when the FIFO held fewer bytes than the requested payload length at the moment the frame started. In that case the frame is cut short after the last byte the FIFO could supply, and no CRC is sent.

Top module: `pkt_tx_framer`

## Requirements
- R1: Fields leave in this fixed order: preamble, start pattern, node address (if enabled), length byte (if enabled), payload, CRC high byte, CRC low byte (if enabled). Every byte is sent most significant bit first.
- R2: The preamble is `cfg_pre_len`+1 copies of `cfg_pre_byte`. The start pattern is the `cfg_sync_len`+1 most significant bytes of `cfg_sync`, sent from the top byte downward.
- R3: The payload is always `cfg_pay_len` bytes. With `cfg_var_len`=1 a length byte equal to `cfg_pay_len` is inserted before the payload. With `cfg_var_len`=0 no length byte is sent. With `cfg_addr_en`=1 the byte `cfg_addr` is sent ahead of the length byte.
- R4: With `cfg_crc_en`=1 the frame ends with a CRC over the address, length and payload bytes that were sent, computed bitwise MSB first. The CRC uses polynomial 0x1021, seed 0xFFFF and no final inversion, and its high byte goes first.
- R5: With `cfg_manchester`=1 each bit after the start pattern becomes two chips, a 1 as chips 1,0 and a 0 as chips 0,1. The preamble and start pattern keep one plain chip per bit.
- R6: With `cfg_scramble`=1 each bit after the start pattern is XORed with s[n] before any Manchester step. Here n counts the coded bits of the frame from 0, s[0..8]=1, and s[n]=s[n-9] XOR s[n-5]. The sequence restarts with every frame.
- R7: The FIFO holds `FIFO_DEPTH` bytes. A write while it is full is dropped. Payload bytes leave in the order they were written, and each one is removed once it is sent.
- R8: If the FIFO holds fewer than `cfg_pay_len` bytes at start, `underrun` is 1 from the next cycle until the next accepted start. The frame then ends after the last stored payload byte, with no CRC. Otherwise `underrun` is 0.
- R9: A start while idle raises `busy` in the next cycle, with the first chip on `tx_bit`. Each `bit_tick` while busy moves to the next chip one cycle later. After the strobe of the final chip, `busy` falls and `done` is 1 for exactly one cycle. `tx_bit` is 0 while idle, and a start while busy is ignored. Reset clears `busy`, `done`, `underrun` and `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Payload byte to store |
| start | input | 1 | Frame start request |
| bit_tick | input | 1 | Chip-rate strobe |
| cfg_pre_len | input | PRE_W | Preamble bytes minus one |
| cfg_pre_byte | input | 8 | Preamble byte value |
| cfg_sync_len | input | SL_W | Start-pattern bytes minus one |
| cfg_sync | input | 8*SYNC_BYTES | Start pattern, top byte first |
| cfg_addr_en | input | 1 | Send node-address byte |
| cfg_addr | input | 8 | Node address |
| cfg_var_len | input | 1 | Send length byte |
| cfg_pay_len | input | LEN_W | Payload length in bytes |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_scramble | input | 1 | Enable whitening |
| cfg_manchester | input | 1 | Enable Manchester chips |
| tx_bit | output | 1 | Serial line chip |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | FIFO was short at start |

## Verification
The bench builds the framer with an 8-byte FIFO, a 2-bit preamble count and a 4-bit payload length. This keeps frames short enough to sweep all 32 combinations of address, length byte, CRC, scrambling and Manchester coding. Across the sweep the preamble length, start-pattern length and payload length are varied, including an empty payload. The small depth also lets the bench overfill the FIFO with a few writes. It can then start frames that meet an empty or partly filled FIFO, and check the dropped bytes and the truncated frame chip by chip against an arithmetic model.

// File: rtl/pkt_tx_pkg.sv
// Shared types and helpers for the packet transmit framer.
// Assumes: field order below is the on-air order; the sequencer relies on it.
package pkt_tx_pkg;

    typedef enum logic [2:0] {
        F_PRE  = 3'd0,
        F_SYNC = 3'd1,
        F_ADDR = 3'd2,
        F_LEN  = 3'd3,
        F_PAY  = 3'd4,
        F_CRCH = 3'd5,
        F_CRCL = 3'd6,
        F_END  = 3'd7
    } field_t;

    localparam int          NUM_FIELDS = 8;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam int          PN_W       = 9;
    localparam logic [PN_W-1:0] PN_SEED = '1;

    // Advance a CRC-16 register over one byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_tx_fifo.sv
// Byte FIFO holding the payload of the next frame.
// Writes while full are dropped; reads while empty are ignored.
// Head byte is presented combinationally. Assumes DEPTH >= 2.
module pkt_tx_fifo #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign empty   = (level == '0);
    assign do_wr   = wr_en && (level != CW'(DEPTH));
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/pkt_tx_coder.sv
// Line coder: optional whitening XOR then optional Manchester split.
// Assumes data_bit and coded stay constant until bit_adv consumes the bit.
// bit_adv marks the strobe that finishes the current data bit.
module pkt_tx_coder
    import pkt_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    input  logic tick,
    input  logic data_bit,
    input  logic coded,
    input  logic scr_en,
    input  logic man_en,
    output logic chip,
    output logic bit_adv
);

    logic            half;
    logic [PN_W-1:0] pn;
    logic            use_man, use_scr, wb;

    assign use_man = coded && man_en;
    assign use_scr = coded && scr_en;

    // Form the current chip and detect the end of a data bit.
    always_comb begin
        wb      = data_bit ^ (use_scr & pn[PN_W-1]);
        chip    = active & ((use_man && half) ? ~wb : wb);
        bit_adv = active && tick && !(use_man && !half);
    end

    // Track the Manchester half and step the whitening sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            half <= 1'b0;
            pn   <= PN_SEED;
        end else if (active && tick) begin
            half <= use_man && !half;
            if (bit_adv && use_scr) pn <= {pn[PN_W-2:0], pn[PN_W-1] ^ pn[4]};
        end
    end

endmodule

// File: rtl/pkt_tx_seq.sv
// Frame sequencer: walks the fields, loads bytes, keeps the CRC.
// Assumes configuration inputs are stable while a frame is active.
// The next byte is chosen combinationally so no chip slot is lost.
module pkt_tx_seq
    import pkt_tx_pkg::*;
#(
    parameter  int PRE_W      = 4,
    parameter  int SYNC_BYTES = 4,
    parameter  int LEN_W      = 8,
    parameter  int LVL_W      = 7,
    localparam int SL_W       = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
    localparam int SYNC_W     = 8 * SYNC_BYTES,
    localparam int FL_W       = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_adv,
    input  logic              fifo_empty,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [7:0]        fifo_head,
    input  logic [PRE_W-1:0]  cfg_pre_len,
    input  logic [7:0]        cfg_pre_byte,
    input  logic [SL_W-1:0]   cfg_sync_len,
    input  logic [SYNC_W-1:0] cfg_sync,
    input  logic              cfg_addr_en,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_var_len,
    input  logic [LEN_W-1:0]  cfg_pay_len,
    input  logic              cfg_crc_en,
    output logic              active,
    output logic              restart,
    output logic              data_bit,
    output logic              coded,
    output logic              fifo_pop,
    output logic              done,
    output logic              underrun
);

    field_t            fld, nf;
    logic [LEN_W-1:0]  cnt, nc;
    logic [7:0]        sh, nbyte;
    logic [2:0]        bitc;
    logic [15:0]       crc;
    logic [NUM_FIELDS-1:0] fen;
    logic [FL_W-1:0]   flen;
    logic              last_in_fld, byte_done, end_now;
    logic [2:0]        nf_idx;
    logic [SYNC_W-1:0] sync_sh;

    assign restart   = !active && start;
    assign data_bit  = sh[7];
    assign coded     = (fld != F_PRE) && (fld != F_SYNC);
    assign byte_done = bit_adv && (bitc == 3'd7);

    // Which fields take part in this frame.
    always_comb begin
        fen         = '1;
        fen[F_ADDR] = cfg_addr_en;
        fen[F_LEN]  = cfg_var_len;
        fen[F_PAY]  = (cfg_pay_len != '0);
        fen[F_CRCH] = cfg_crc_en;
        fen[F_CRCL] = cfg_crc_en;
    end

    // Byte count of the current field.
    always_comb begin
        case (fld)
            F_PRE:   flen = FL_W'(cfg_pre_len) + FL_W'(1);
            F_SYNC:  flen = FL_W'(cfg_sync_len) + FL_W'(1);
            F_PAY:   flen = FL_W'(cfg_pay_len);
            default: flen = FL_W'(1);
        endcase
        last_in_fld = (FL_W'(cnt) == flen - FL_W'(1));
    end

    // Pick the field and index of the byte that follows the current one.
    always_comb begin
        nf_idx = 3'(F_END);
        for (int j = NUM_FIELDS - 1; j >= 0; j--) begin
            if (j > int'(fld) && fen[j]) nf_idx = 3'(j);
        end
        if (last_in_fld) begin
            nf = field_t'(nf_idx);
            nc = '0;
        end else begin
            nf = fld;
            nc = cnt + 1'b1;
        end
        end_now = (nf == F_END) || ((nf == F_PAY) && fifo_empty);
    end

    // Value of the byte that follows.
    always_comb begin
        sync_sh = cfg_sync << (8 * nc);
        case (nf)
            F_PRE:   nbyte = cfg_pre_byte;
            F_SYNC:  nbyte = sync_sh[SYNC_W-1 -: 8];
            F_ADDR:  nbyte = cfg_addr;
            F_LEN:   nbyte = 8'(cfg_pay_len);
            F_PAY:   nbyte = fifo_head;
            F_CRCH:  nbyte = crc[15:8];
            F_CRCL:  nbyte = crc[7:0];
            default: nbyte = 8'h00;
        endcase
    end

    assign fifo_pop = active && byte_done && !end_now && (nf == F_PAY);

    // Frame control: start, bit shifting, byte loading, end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            fld      <= F_END;
            cnt      <= '0;
            sh       <= '0;
            bitc     <= '0;
            crc      <= CRC_SEED;
            done     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    fld      <= F_PRE;
                    cnt      <= '0;
                    sh       <= cfg_pre_byte;
                    bitc     <= '0;
                    crc      <= CRC_SEED;
                    underrun <= int'(fifo_level) < int'(cfg_pay_len);
                end
            end else if (bit_adv) begin
                if (bitc != 3'd7) begin
                    bitc <= bitc + 1'b1;
                    sh   <= {sh[6:0], 1'b0};
                end else begin
                    bitc <= '0;
                    if (end_now) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        fld    <= F_END;
                    end else begin
                        fld <= nf;
                        cnt <= nc;
                        sh  <= nbyte;
                        if (nf == F_ADDR || nf == F_LEN || nf == F_PAY)
                            crc <= crc16_byte(crc, nbyte);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pkt_tx_framer.sv
// Packet transmit framer top: FIFO, field sequencer and line coder.
// Assumes bit_tick is a single-cycle strobe and configuration is held
// steady from start until done.
module pkt_tx_framer #(
    parameter  int FIFO_DEPTH = 64,
    parameter  int PRE_W      = 4,
    parameter  int SYNC_BYTES = 4,
    parameter  int LEN_W      = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
    localparam int SL_W       = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
    localparam int SYNC_W     = 8 * SYNC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              start,
    input  logic              bit_tick,
    input  logic [PRE_W-1:0]  cfg_pre_len,
    input  logic [7:0]        cfg_pre_byte,
    input  logic [SL_W-1:0]   cfg_sync_len,
    input  logic [SYNC_W-1:0] cfg_sync,
    input  logic              cfg_addr_en,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_var_len,
    input  logic [LEN_W-1:0]  cfg_pay_len,
    input  logic              cfg_crc_en,
    input  logic              cfg_scramble,
    input  logic              cfg_manchester,
    output logic              tx_bit,
    output logic              busy,
    output logic              done,
    output logic              underrun
);

    logic             fifo_pop, fifo_empty;
    logic [7:0]       fifo_head;
    logic [LVL_W-1:0] fifo_level;
    logic             active, restart, data_bit, coded, bit_adv, chip;

    pkt_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (fifo_pop),
        .rd_data (fifo_head),
        .level   (fifo_level),
        .empty   (fifo_empty)
    );

    pkt_tx_seq #(
        .PRE_W(PRE_W), .SYNC_BYTES(SYNC_BYTES), .LEN_W(LEN_W), .LVL_W(LVL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .bit_adv      (bit_adv),
        .fifo_empty   (fifo_empty),
        .fifo_level   (fifo_level),
        .fifo_head    (fifo_head),
        .cfg_pre_len  (cfg_pre_len),
        .cfg_pre_byte (cfg_pre_byte),
        .cfg_sync_len (cfg_sync_len),
        .cfg_sync     (cfg_sync),
        .cfg_addr_en  (cfg_addr_en),
        .cfg_addr     (cfg_addr),
        .cfg_var_len  (cfg_var_len),
        .cfg_pay_len  (cfg_pay_len),
        .cfg_crc_en   (cfg_crc_en),
        .active       (active),
        .restart      (restart),
        .data_bit     (data_bit),
        .coded        (coded),
        .fifo_pop     (fifo_pop),
        .done         (done),
        .underrun     (underrun)
    );

    pkt_tx_coder u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .active   (active),
        .tick     (bit_tick),
        .data_bit (data_bit),
        .coded    (coded),
        .scr_en   (cfg_scramble),
        .man_en   (cfg_manchester),
        .chip     (chip),
        .bit_adv  (bit_adv)
    );

    assign tx_bit = chip;
    assign busy   = active;

endmodule

// File: rtl/pkt_tx_checker.sv
// Protocol checks on the framer's ports, bound into every instance.
module pkt_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bit_tick,
    input logic tx_bit,
    input logic busy,
    input logic done,
    input logic underrun
);

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_bit); // R9

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_CHIP_HELD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(bit_tick)) |-> $stable(tx_bit)); // R9

    AST_UNDERRUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(underrun)); // R8

endmodule

bind pkt_tx_framer pkt_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bit_tick (bit_tick),
    .tx_bit   (tx_bit),
    .busy     (busy),
    .done     (done),
    .underrun (underrun)
);

// File: tb/test_pkt_tx_framer.sv
// Self-checking bench: sweeps frame options on a small build and compares
// every chip with an arithmetic frame model.
module test_pkt_tx_framer;

    localparam int DEPTH = 8;
    localparam int PRE_W = 2;
    localparam int LEN_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic        bit_tick = 1'b0;
    logic [PRE_W-1:0] cfg_pre_len = '0;
    logic [7:0]  cfg_pre_byte = 8'hAA;
    logic [1:0]  cfg_sync_len = '0;
    logic [31:0] cfg_sync = 32'h2DD4_9C61;
    logic        cfg_addr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h5A;
    logic        cfg_var_len = 1'b0;
    logic [LEN_W-1:0] cfg_pay_len = '0;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_scramble = 1'b0;
    logic        cfg_manchester = 1'b0;
    logic        tx_bit, busy, done, underrun;

    int checks = 0;
    int errors = 0;

    logic [7:0] mq[$];
    logic [7:0] eb [0:63];
    bit         ecod [0:63];
    int         nb;
    bit         xc [0:4095];
    int         nx;
    bit         cap [0:4095];
    int         ncap;
    bit         cap_on = 1'b0;
    bit         exp_under;
    bit         pn [0:4095];

    pkt_tx_framer #(.FIFO_DEPTH(DEPTH), .PRE_W(PRE_W), .SYNC_BYTES(4), .LEN_W(LEN_W))
    i_pkt_tx_framer (.*);

    always #10 clk = ~clk;

    // Chip-rate strobe: one cycle high in every four.
    initial begin
        forever begin
            bit_tick = 1'b0;
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
        end
    end

    // Record each chip in the cycle its strobe consumes it.
    always @(negedge clk) begin
        if (cap_on && busy && bit_tick) begin
            cap[ncap] = tx_bit;
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_model(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ d[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic push_byte(input logic [7:0] b, input bit coded);
        eb[nb]   = b;
        ecod[nb] = coded;
        nb++;
    endtask

    // Build the expected chip list (R1..R8) and consume the model FIFO.
    task automatic build_exp();
        logic [15:0] c;
        int avail, n;
        nb = 0;
        c = 16'hFFFF;
        exp_under = (mq.size() < int'(cfg_pay_len));
        for (int k = 0; k <= int'(cfg_pre_len); k++) push_byte(cfg_pre_byte, 1'b0);
        for (int k = 0; k <= int'(cfg_sync_len); k++) push_byte(cfg_sync[31 - 8*k -: 8], 1'b0);
        if (cfg_addr_en) begin push_byte(cfg_addr, 1'b1); c = crc_model(c, cfg_addr); end
        if (cfg_var_len) begin push_byte(8'(cfg_pay_len), 1'b1); c = crc_model(c, 8'(cfg_pay_len)); end
        avail = exp_under ? mq.size() : int'(cfg_pay_len);
        for (int k = 0; k < avail; k++) begin
            logic [7:0] b;
            b = mq.pop_front();
            push_byte(b, 1'b1);
            c = crc_model(c, b);
        end
        if (cfg_crc_en && !exp_under) begin
            push_byte(c[15:8], 1'b1);
            push_byte(c[7:0], 1'b1);
        end
        nx = 0;
        n = 0;
        for (int k = 0; k < nb; k++) begin
            for (int i = 7; i >= 0; i--) begin
                bit b;
                b = eb[k][i];
                if (ecod[k]) begin
                    if (cfg_scramble) b = b ^ pn[n];
                    n++;
                    if (cfg_manchester) begin
                        xc[nx] = b; xc[nx+1] = ~b; nx += 2;
                    end else begin
                        xc[nx] = b; nx++;
                    end
                end else begin
                    xc[nx] = b; nx++;
                end
            end
        end
    endtask

    task automatic write_bytes(input int cnt, input int seed);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = 8'((seed * 37 + i * 11 + 3) & 8'hFF);
            if (mq.size() < DEPTH) mq.push_back(wr_data);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Send one frame and compare it; poke=1 adds a start while busy (R9).
    task automatic run_pkt(input string tag, input bit poke);
        int bad;
        build_exp();
        ncap   = 0;
        cap_on = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R9", "busy low at done", int'(busy), 0);
        cap_on = 1'b0;
        chk(ncap == nx, tag, "chip count", ncap, nx);
        bad = -1;
        for (int i = 0; i < nx && i < ncap; i++) if (bad < 0 && cap[i] != xc[i]) bad = i;
        chk(bad < 0, tag, "first wrong chip index", bad, -1);
        chk(underrun === exp_under, "R8", "underrun flag", int'(underrun), int'(exp_under));
        @(negedge clk);
        chk(done === 1'b0, "R9", "done width", int'(done), 0);
        chk(busy === 1'b0, "R9", "no restart from start while busy", int'(busy), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 4096; n++) pn[n] = (n < 9) ? 1'b1 : (pn[n-9] ^ pn[n-5]);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(busy === 1'b0 && done === 1'b0, "R9", "reset busy/done", int'(busy | done), 0);
        chk(tx_bit === 1'b0, "R9", "reset line", int'(tx_bit), 0);
        chk(underrun === 1'b0, "R8", "reset underrun", int'(underrun), 0);

        // Sweep every option combination (R1 R2 R3 R4 R5 R6 R7).
        for (int c = 0; c < 32; c++) begin
            string tag;
            cfg_addr_en    = c[0];
            cfg_var_len    = c[1];
            cfg_crc_en     = c[2];
            cfg_scramble   = c[3];
            cfg_manchester = c[4];
            cfg_pre_len    = PRE_W'(c % 4);
            cfg_sync_len   = 2'((c / 4) % 4);
            cfg_pay_len    = LEN_W'(c % 9);
            cfg_addr       = 8'(c * 29 + 1);
            write_bytes(c % 9, c);
            if (cfg_manchester)    tag = "R5";
            else if (cfg_scramble) tag = "R6";
            else if (cfg_crc_en)   tag = "R4";
            else if (cfg_var_len)  tag = "R3";
            else if (c % 4 != 0)   tag = "R2";
            else                   tag = "R1";
            run_pkt(tag, 1'b0);
        end

        // R7: overfill, full-depth payload, then writes beyond depth are gone.
        cfg_addr_en = 1'b0; cfg_var_len = 1'b1; cfg_crc_en = 1'b1;
        cfg_scramble = 1'b0; cfg_manchester = 1'b0;
        cfg_pre_len = 2'd1; cfg_sync_len = 2'd3;
        write_bytes(DEPTH + 2, 77);
        cfg_pay_len = LEN_W'(DEPTH);
        run_pkt("R7", 1'b0);
        // R8: FIFO now empty, frame stops before any payload.
        cfg_pay_len = 4'd2;
        run_pkt("R8", 1'b0);
        // R8: partial payload, coded, no CRC.
        cfg_scramble = 1'b1; cfg_manchester = 1'b1; cfg_addr_en = 1'b1;
        write_bytes(3, 5);
        cfg_pay_len = 4'd6;
        run_pkt("R8", 1'b0);
        // R8: flag clears on the next healthy frame; R9: start while busy ignored.
        write_bytes(4, 9);
        cfg_pay_len = 4'd4;
        run_pkt("R9", 1'b1);
        chk(underrun === 1'b0, "R8", "flag cleared", int'(underrun), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule